// File: doc/BRIEF.md
# Cascaded Divide-by-33 Frequency Divider

This block divides a selected clock source by 33 in two synchronous stages, all inside one system clock domain. Each of the three sources is an enable pulse: a slow rectangular source, a fast rectangular source, and a manual single step that has already been debounced. A selector picks which pulse advances the divider. The other pulses, and the unused selector code, leave it idle.

The first stage is a 4-bit binary counter with a synchronous load. Reset presets it to 5. It counts up to all-ones and, on the next advance, reloads 5, so its cycle has eleven states. While it holds 15, it drives a terminal-count strobe. That strobe gates a second stage made of two flip-flops with NOR feedback. The second stage walks through three states, and the final output is high in the last of them. The counter value is brought out so it can be observed.

Top module: `div33_cascade`

## Requirements
- R1: While `srst` is high at a rising `clk` edge, that edge sets `count_q` to 5 and clears the divide-by-3 state, whatever the tick and select inputs are. After that edge, `tc11` and `out33` are 0.
- R2: `src_sel` chooses the advance source. The encoding is 0 for `slow_tick`, 1 for `fast_tick`, 2 for `step_tick`, and 3 for no source. Ticks on sources that are not selected have no effect.
- R3: On each advance where `count_q` is not 15, `count_q` increases by exactly one.
- R4: On an advance where `count_q` is 15, `count_q` loads 5. The counter therefore cycles through 11 values, 5 to 15.
- R5: `tc11` is high exactly while `count_q` equals 15. It therefore lasts one advance period in every eleven.
- R6: The divide-by-3 stage moves only on an advance while `tc11` is high. It steps through three states in order and never enters a fourth.
- R7: After reset, `out33` first rises on the 22nd advance. From then on it rises every 33 advances and stays high for 11 advances each time.
- R8: On a clock with no advance, `count_q`, `tc11` and `out33` all hold.
- R9: With an advance on every clock, `tc11` repeats every 11 clocks and `out33` repeats every 33 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Active-high synchronous reset |
| src_sel | input | 2 | Source select: 0 slow, 1 fast, 2 manual, 3 none |
| slow_tick | input | 1 | Enable pulse from the slow source |
| fast_tick | input | 1 | Enable pulse from the fast source |
| step_tick | input | 1 | Debounced manual step pulse |
| count_q | output | 4 | First-stage counter value |
| tc11 | output | 1 | Divide-by-11 terminal-count strobe |
| out33 | output | 1 | Divide-by-33 output |

## Verification
The bench first drives an advance on every clock. This shows the 11-clock and 33-clock periods with no gaps. Next, the slow source is selected and pulses sparsely, while the other two inputs toggle pseudo-randomly. This pattern exposes any decode of the wrong tick. Manual steps at random spacing follow, started after the selector was changed while the block was held in reset. A later phase uses select code 3 with all ticks active, and a mid-count reset lands partway through a cycle. Together these separate the hold behaviour and the reset preset from the normal reload and divide-by-3 sequencing. Throughout, every count of advances between rises of `out33` is compared against 22 after reset and 33 afterwards.

// File: rtl/div33_cascade.sv
module div33_cascade #(
  parameter int CW       = 4,
  parameter int LOAD_VAL = 5
) (
  input  logic          clk,
  input  logic          srst,
  input  logic [1:0]    src_sel,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic          step_tick,
  output logic [CW-1:0] count_q,
  output logic          tc11,
  output logic          out33
);

  localparam logic [CW-1:0] PRESET = CW'(LOAD_VAL);

  logic          adv;
  logic [CW-1:0] cnt;
  logic          q0, q1;

  always_comb begin
    case (src_sel)
      2'd0:    adv = slow_tick;
      2'd1:    adv = fast_tick;
      2'd2:    adv = step_tick;
      default: adv = 1'b0;
    endcase
  end

  assign tc11 = &cnt;

  always_ff @(posedge clk) begin
    if (srst)      cnt <= PRESET;
    else if (adv)  cnt <= tc11 ? PRESET : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      q0 <= 1'b0;
      q1 <= 1'b0;
    end else if (adv && tc11) begin
      q0 <= ~(q0 | q1);
      q1 <= q0;
    end
  end

  assign count_q = cnt;
  assign out33   = q1;

  a_r1_reset_state: assert property (@(posedge clk)
    srst |=> (count_q == PRESET) && !out33 && !tc11);

  a_r3_step_up: assert property (@(posedge clk) disable iff (srst)
    (adv && count_q != {CW{1'b1}}) |=> count_q == $past(count_q) + 1'b1);

  a_r4_reload: assert property (@(posedge clk) disable iff (srst)
    (adv && count_q == {CW{1'b1}}) |=> count_q == PRESET);

  a_r8_hold: assert property (@(posedge clk) disable iff (srst)
    !adv |=> $stable(count_q) && $stable(out33));

  a_r6_gated: assert property (@(posedge clk) disable iff (srst)
    !(adv && tc11) |=> $stable(q0) && $stable(q1));

  a_r6_legal_state: assert property (@(posedge clk) disable iff (srst)
    !(q0 && q1));

endmodule

// File: tb/div33_cascade_test.sv
`timescale 1ns/1ps
module div33_cascade_test;
  logic clk = 1'b0;
  logic srst = 1'b1;
  logic [1:0] src_sel = 2'd1;
  logic slow_tick = 1'b0, fast_tick = 1'b0, step_tick = 1'b0;
  logic [3:0] count_q;
  logic tc11, out33;

  div33_cascade uut (
    .clk(clk), .srst(srst), .src_sel(src_sel),
    .slow_tick(slow_tick), .fast_tick(fast_tick), .step_tick(step_tick),
    .count_q(count_q), .tc11(tc11), .out33(out33)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, errs = 0;
  int ticks = 0;
  int since_rise = 0;
  bit first_rise = 1'b1;
  bit prev_out = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    errs++;
    $display("FAIL watchdog: run did not end, got running exp done");
    finish_run();
  end

  task automatic chk(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  // Apply one cycle of stimulus, then compare against the behavioural model.
  task automatic cyc(string phase, bit rst, logic [1:0] sel,
                     bit st, bit ft, bit mt);
    bit a;
    int exp_cnt, exp_tc, exp_out;
    srst = rst; src_sel = sel;
    slow_tick = st; fast_tick = ft; step_tick = mt;
    a = (sel == 2'd0) ? st : (sel == 2'd1) ? ft : (sel == 2'd2) ? mt : 1'b0;
    @(posedge clk);
    if (rst) begin
      ticks = 0; since_rise = 0; first_rise = 1'b1;
    end else if (a) begin
      ticks++; since_rise++;
    end
    @(negedge clk);
    exp_cnt = 5 + (ticks % 11);
    exp_tc  = (exp_cnt == 15);
    exp_out = ((ticks / 11) % 3) == 2;
    chk("R3/R4", {phase, " count_q"}, count_q, exp_cnt);
    chk("R5",    {phase, " tc11"},    tc11,    exp_tc);
    chk("R7",    {phase, " out33"},   out33,   exp_out);
    if (out33 && !prev_out) begin
      chk("R7/R9", {phase, " advances between out33 rises"}, since_rise,
          first_rise ? 22 : 33);
      first_rise = 1'b0;
      since_rise = 0;
    end
    prev_out = out33;
  endtask

  function automatic logic [15:0] nxt(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    // R1: reset with all ticks active
    for (int i = 0; i < 3; i++) cyc("R1 reset", 1, 2'd1, 1, 1, 1);
    chk("R1", "count_q after reset", count_q, 5);
    chk("R1", "out33 after reset", out33, 0);
    chk("R1", "tc11 after reset", tc11, 0);

    // R9: an advance on every clock
    for (int i = 0; i < 140; i++) cyc("R9 fast every clock", 0, 2'd1, 0, 1, 0);

    // R2: slow source selected, others noisy
    for (int i = 0; i < 700; i++) begin
      lfsr = nxt(lfsr);
      cyc("R2 slow sparse", 0, 2'd0, (i % 7) == 0, lfsr[0], lfsr[1]);
    end

    // R1/R2: source changed while held in reset, then manual steps
    for (int i = 0; i < 4; i++) cyc("R1 reset switch", 1, 2'(i % 3), 1, 1, 1);
    chk("R1", "count_q after switch reset", count_q, 5);
    for (int i = 0; i < 400; i++) begin
      lfsr = nxt(lfsr);
      cyc("R2 manual steps", 0, 2'd2, lfsr[2], lfsr[3], lfsr[4] & lfsr[5]);
    end

    // R8: no source selected, all ticks active
    begin
      logic [3:0] c0; logic o0;
      c0 = count_q; o0 = out33;
      for (int i = 0; i < 40; i++) begin
        lfsr = nxt(lfsr);
        cyc("R8 no source", 0, 2'd3, lfsr[0], 1, lfsr[1]);
      end
      chk("R8", "count_q held", count_q, c0);
      chk("R8", "out33 held", out33, o0);
    end

    // R1: reset mid-count, then full-rate run
    for (int i = 0; i < 17; i++) cyc("R4 pre", 0, 2'd1, 0, 1, 0);
    cyc("R1 mid reset", 1, 2'd1, 0, 1, 0);
    chk("R1", "count_q mid reset", count_q, 5);
    for (int i = 0; i < 120; i++) cyc("R6 after mid reset", 0, 2'd1, 0, 1, 0);

    finish_run();
  end
endmodule